// File: doc/BRIEF.md
# Multi-Stage Tile Ring Stage Controller

This block keeps a ring of tile slots in order between a producer that fills them and a consumer that drains them. The producer acquires the slot for its next iteration, which is slot `k mod N_STAGES` for iteration `k`, and states how many bytes its two operand tiles will occupy. A copy engine then reports arrivals of bytes against a slot. When the arrivals add up exactly to the stated total, the slot counts as filled and the consumer may work on it. When the consumer releases the slot, the producer may reuse it on its next lap.

Each slot has a fill barrier and a drain barrier. Each barrier carries a phase bit that flips whenever the barrier completes. Each side keeps its own lap phase. A side may use a slot only when the slot's barrier phase matches the lap that side is on, so a slot filled on one lap is never taken for a slot of the previous or the next lap. The controller also gives the byte offset of the current slot inside a buffer of `N_STAGES × SLOT_BYTES` bytes. It raises a one-cycle error when an arrival cannot be accounted for. Buffer storage, the copy engine and the compute unit sit outside the block.

Top module: `stage_ring_ctrl`

## Requirements
- R1: After reset every slot counts as drained: `prod_ready`=1, `cons_ready`=0, both stage indices are 0, both lap phases are 0, all bits of `fill_phase`, `drain_phase` and `armed` are 0, and `fill_err`=0.
- R2: Each accepted acquire (`prod_acq` high while `prod_ready` is high) moves `prod_stage` to `(prod_stage+1) mod N_STAGES`. `prod_lap` inverts when the index wraps from N_STAGES-1 to 0. `prod_slot_addr` always equals `prod_stage × SLOT_BYTES`.
- R3: `prod_ready` is 1 exactly when `drain_phase[prod_stage]` equals `prod_lap`. The producer can therefore take the first N_STAGES slots with no release, and then stalls. An acquire while `prod_ready` is 0 changes nothing.
- R4: An accepted acquire with a non-zero total `bytes_a+bytes_b` sets `armed[stage]`. While the summed arrivals are below that total, the slot stays unfilled. The arrival that makes the sum equal to the total inverts `fill_phase[stage]`, clears `armed[stage]`, and this is visible the cycle after that arrival.
- R5: An accepted acquire with a total of zero bytes completes the fill barrier of that slot at once: `fill_phase` inverts after that edge and `armed` stays 0.
- R6: `cons_ready` is 1 exactly when `fill_phase[cons_stage]` differs from `cons_lap`. A release while `cons_ready` is 1 moves `cons_stage` to `(cons_stage+1) mod N_STAGES`, inverts `cons_lap` on the wrap, and sets `cons_slot_addr` to `cons_stage × SLOT_BYTES`. A release while `cons_ready` is 0 changes nothing.
- R7: An accepted release inverts `drain_phase[cons_stage]`, and the producer may then reuse that slot on its next lap.
- R8: An arrival whose bytes would take a slot's sum above its armed total is discarded: the sum and `armed` keep their values. `fill_err` is 1 for the next cycle, with `fill_err_stage` holding the arrival's stage.
- R9: An arrival aimed at a slot that is not armed, or at a stage number ≥ N_STAGES, is discarded and raises `fill_err` in the same way as R8.
- R10: N_STAGES must lie in 3..5. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_acq | input | 1 | Producer requests its next slot |
| bytes_a | input | BYTE_W | Bytes expected for operand tile A |
| bytes_b | input | BYTE_W | Bytes expected for operand tile B |
| prod_ready | output | 1 | Producer's slot has been drained on this lap |
| prod_stage | output | IDX_W | Producer's slot index |
| prod_lap | output | 1 | Producer's lap phase |
| prod_slot_addr | output | ADDR_W | Byte offset of the producer's slot |
| arr_valid | input | 1 | Copy engine reports an arrival |
| arr_stage | input | IDX_W | Slot the arrival belongs to |
| arr_bytes | input | BYTE_W+1 | Bytes in this arrival |
| cons_release | input | 1 | Consumer finished its slot |
| cons_ready | output | 1 | Consumer's slot is filled on this lap |
| cons_stage | output | IDX_W | Consumer's slot index |
| cons_lap | output | 1 | Consumer's lap phase |
| cons_slot_addr | output | ADDR_W | Byte offset of the consumer's slot |
| fill_phase | output | N_STAGES | Fill barrier phase per slot |
| drain_phase | output | N_STAGES | Drain barrier phase per slot |
| armed | output | N_STAGES | Slot waiting for arrivals |
| fill_err | output | 1 | One-cycle flag for a discarded arrival |
| fill_err_stage | output | IDX_W | Stage of the discarded arrival |

## Verification
The bench builds the block with N_STAGES=3, BYTE_W=4 and SLOT_BYTES=16. Three slots take the ring index through the compare-based wrap and leave stage code 3 free, so the out-of-range arrival in R9 can be driven. Totals of at most 30 bytes keep the exact-match point and the one-byte overshoot close together, so random arrivals land on both often. Thousands of random cycles carry both sides through many laps, which exercises the phase matching of R3 and R6 long after the ring first fills.

// File: rtl/stage_ring_pkg.sv
package stage_ring_pkg;

   // Index width for a ring of n slots (at least one bit).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // How a barrier judges one arrival.
   typedef enum logic [1:0] {
      ARR_NONE   = 2'd0,
      ARR_ACCUM  = 2'd1,
      ARR_DONE   = 2'd2,
      ARR_REJECT = 2'd3
   } arr_verdict_e;

endpackage

// File: rtl/stage_ring_index.sv
module stage_ring_index #(
   parameter  int unsigned N_STAGES = 3,
   localparam int unsigned IDX_W    = stage_ring_pkg::idx_width(N_STAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] idx,
   output logic             lap
);

   localparam bit IS_POW2 = ((N_STAGES & (N_STAGES - 1)) == 0);

   logic at_last;

   generate
      if (IS_POW2) begin : g_pow2_wrap
         assign at_last = &idx;
      end else begin : g_cmp_wrap
         assign at_last = (idx == IDX_W'(N_STAGES - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
         lap <= 1'b0;
      end else if (advance) begin
         if (at_last) begin
            idx <= '0;
            lap <= ~lap;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R2 / R6: leaving the last slot returns to slot 0 on the other lap
   a_r2_wrap_flips_lap : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && idx == IDX_W'(N_STAGES - 1)) |=> (idx == '0 && lap != $past(lap)));

   a_r2_hold_without_advance : assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> ($stable(idx) && $stable(lap)));

endmodule

// File: rtl/stage_barrier.sv
module stage_barrier #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic [CNT_W-1:0] arm_total_i,
   input  logic             arr_i,
   input  logic [CNT_W-1:0] arr_bytes_i,
   input  logic             release_i,
   output logic             fill_phase_o,
   output logic             drain_phase_o,
   output logic             armed_o,
   output logic             reject_o
);
   import stage_ring_pkg::*;

   logic [CNT_W-1:0] expect_q;
   logic [CNT_W-1:0] sum_q;
   logic [CNT_W:0]   sum_next;
   arr_verdict_e     verdict;

   assign sum_next = {1'b0, sum_q} + {1'b0, arr_bytes_i};

   always_comb begin
      if (!arr_i)                              verdict = ARR_NONE;
      else if (!armed_o)                       verdict = ARR_REJECT;
      else if (sum_next > {1'b0, expect_q})    verdict = ARR_REJECT;
      else if (sum_next == {1'b0, expect_q})   verdict = ARR_DONE;
      else                                     verdict = ARR_ACCUM;
   end

   assign reject_o = (verdict == ARR_REJECT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         expect_q      <= '0;
         sum_q         <= '0;
         armed_o       <= 1'b0;
         fill_phase_o  <= 1'b0;
      end else if (arm_i) begin
         sum_q <= '0;
         if (arm_total_i == '0) begin
            fill_phase_o <= ~fill_phase_o;
         end else begin
            armed_o  <= 1'b1;
            expect_q <= arm_total_i;
         end
      end else begin
         case (verdict)
            ARR_ACCUM: sum_q <= sum_next[CNT_W-1:0];
            ARR_DONE: begin
               sum_q        <= '0;
               armed_o      <= 1'b0;
               fill_phase_o <= ~fill_phase_o;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          drain_phase_o <= 1'b0;
      else if (release_i)  drain_phase_o <= ~drain_phase_o;
   end

   // R4: fill barrier cannot complete unless it was armed or armed now
   a_r4_fill_needs_arm : assert property (@(posedge clk) disable iff (!rst_n)
      (!arm_i && !armed_o) |=> $stable(fill_phase_o));

   // R8: a rejected arrival leaves the byte sum and arming untouched
   a_r8_reject_keeps_sum : assert property (@(posedge clk) disable iff (!rst_n)
      (reject_o && !arm_i) |=> ($stable(sum_q) && $stable(armed_o)));

   // R7: drain phase only moves on release
   a_r7_drain_on_release : assert property (@(posedge clk) disable iff (!rst_n)
      !release_i |=> $stable(drain_phase_o));

endmodule

// File: rtl/stage_ring_ctrl.sv
module stage_ring_ctrl #(
   parameter  int unsigned N_STAGES   = 3,
   parameter  int unsigned BYTE_W     = 4,
   parameter  int unsigned SLOT_BYTES = 16,
   localparam int unsigned IDX_W      = stage_ring_pkg::idx_width(N_STAGES),
   localparam int unsigned CNT_W      = BYTE_W + 1,
   localparam int unsigned ADDR_W     = $clog2(N_STAGES * SLOT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prod_acq,
   input  logic [BYTE_W-1:0] bytes_a,
   input  logic [BYTE_W-1:0] bytes_b,
   output logic              prod_ready,
   output logic [IDX_W-1:0]  prod_stage,
   output logic              prod_lap,
   output logic [ADDR_W-1:0] prod_slot_addr,
   input  logic              arr_valid,
   input  logic [IDX_W-1:0]  arr_stage,
   input  logic [CNT_W-1:0]  arr_bytes,
   input  logic              cons_release,
   output logic              cons_ready,
   output logic [IDX_W-1:0]  cons_stage,
   output logic              cons_lap,
   output logic [ADDR_W-1:0] cons_slot_addr,
   output logic [N_STAGES-1:0] fill_phase,
   output logic [N_STAGES-1:0] drain_phase,
   output logic [N_STAGES-1:0] armed,
   output logic              fill_err,
   output logic [IDX_W-1:0]  fill_err_stage
);

   // R10: elaboration-time parameter checks
   generate
      if (N_STAGES < 3 || N_STAGES > 5) begin : g_bad_stages
         $error("stage_ring_ctrl: N_STAGES must be 3..5");
      end
      if (BYTE_W < 1) begin : g_bad_bytew
         $error("stage_ring_ctrl: BYTE_W must be at least 1");
      end
      if (SLOT_BYTES < 1) begin : g_bad_slot
         $error("stage_ring_ctrl: SLOT_BYTES must be at least 1");
      end
   endgenerate

   logic              acq_fire;
   logic              rel_fire;
   logic [CNT_W-1:0]  acq_total;
   logic              arr_out_of_range;
   logic [N_STAGES-1:0] reject;

   assign acq_total = {1'b0, bytes_a} + {1'b0, bytes_b};

   stage_ring_index #(.N_STAGES(N_STAGES)) i_prod_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (acq_fire),
      .idx     (prod_stage),
      .lap     (prod_lap)
   );

   stage_ring_index #(.N_STAGES(N_STAGES)) i_cons_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (rel_fire),
      .idx     (cons_stage),
      .lap     (cons_lap)
   );

   // Wait conditions: pick the barrier phase of the current slot
   always_comb begin
      prod_ready = 1'b0;
      cons_ready = 1'b0;
      for (int s = 0; s < N_STAGES; s++) begin
         if (prod_stage == IDX_W'(s)) prod_ready = (drain_phase[s] == prod_lap);
         if (cons_stage == IDX_W'(s)) cons_ready = (fill_phase[s] != cons_lap);
      end
   end

   assign acq_fire = prod_acq && prod_ready;
   assign rel_fire = cons_release && cons_ready;

   assign prod_slot_addr = ADDR_W'(prod_stage) * ADDR_W'(SLOT_BYTES);
   assign cons_slot_addr = ADDR_W'(cons_stage) * ADDR_W'(SLOT_BYTES);

   assign arr_out_of_range = arr_valid && ({1'b0, arr_stage} >= (IDX_W + 1)'(N_STAGES));

   generate
      for (genvar s = 0; s < N_STAGES; s++) begin : g_slot
         stage_barrier #(.CNT_W(CNT_W)) i_barrier (
            .clk           (clk),
            .rst_n         (rst_n),
            .arm_i         (acq_fire && prod_stage == IDX_W'(s)),
            .arm_total_i   (acq_total),
            .arr_i         (arr_valid && arr_stage == IDX_W'(s)),
            .arr_bytes_i   (arr_bytes),
            .release_i     (rel_fire && cons_stage == IDX_W'(s)),
            .fill_phase_o  (fill_phase[s]),
            .drain_phase_o (drain_phase[s]),
            .armed_o       (armed[s]),
            .reject_o      (reject[s])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_err       <= 1'b0;
         fill_err_stage <= '0;
      end else begin
         fill_err       <= arr_out_of_range || (|reject);
         fill_err_stage <= arr_stage;
      end
   end

   // R3: a refused acquire leaves the producer where it was
   a_r3_refused_acquire_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (prod_acq && !prod_ready) |=> ($stable(prod_stage) && $stable(prod_lap)));

   // R6: a release on an unfilled slot is ignored
   a_r6_early_release_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (cons_release && !cons_ready) |=> ($stable(cons_stage) && $stable(cons_lap)));

   // R9: arrivals past the ring always flag an error
   a_r9_range_flags_error : assert property (@(posedge clk) disable iff (!rst_n)
      arr_out_of_range |=> (fill_err && fill_err_stage == $past(arr_stage)));

   // R8: no arrival, no error
   a_r8_error_needs_arrival : assert property (@(posedge clk) disable iff (!rst_n)
      !arr_valid |=> !fill_err);

   // R3/R6: consumer never sits on the slot the producer is about to fill
   a_r3_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
      (prod_stage == cons_stage && prod_lap != cons_lap) |-> !prod_ready);

endmodule

// File: tb/test_stage_ring_ctrl.sv
module test_stage_ring_ctrl;

   localparam int NS   = 3;
   localparam int BW   = 4;
   localparam int SLOT = 16;
   localparam int IW   = 2;
   localparam int CW   = BW + 1;
   localparam int AW   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prod_acq = 1'b0;
   logic [BW-1:0] bytes_a = '0, bytes_b = '0;
   logic prod_ready, prod_lap, cons_ready, cons_lap, fill_err;
   logic [IW-1:0] prod_stage, cons_stage, fill_err_stage;
   logic [AW-1:0] prod_slot_addr, cons_slot_addr;
   logic arr_valid = 1'b0;
   logic [IW-1:0] arr_stage = '0;
   logic [CW-1:0] arr_bytes = '0;
   logic cons_release = 1'b0;
   logic [NS-1:0] fill_phase, drain_phase, armed;

   always #5 clk = ~clk;

   stage_ring_ctrl #(.N_STAGES(NS), .BYTE_W(BW), .SLOT_BYTES(SLOT)) i_stage_ring_ctrl (
      .clk(clk), .rst_n(rst_n), .prod_acq(prod_acq), .bytes_a(bytes_a), .bytes_b(bytes_b),
      .prod_ready(prod_ready), .prod_stage(prod_stage), .prod_lap(prod_lap),
      .prod_slot_addr(prod_slot_addr), .arr_valid(arr_valid), .arr_stage(arr_stage),
      .arr_bytes(arr_bytes), .cons_release(cons_release), .cons_ready(cons_ready),
      .cons_stage(cons_stage), .cons_lap(cons_lap), .cons_slot_addr(cons_slot_addr),
      .fill_phase(fill_phase), .drain_phase(drain_phase), .armed(armed),
      .fill_err(fill_err), .fill_err_stage(fill_err_stage));

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Reference state built from the requirements
   int m_pidx, m_pph, m_cidx, m_cph, m_err, m_errst;
   int m_fill[NS], m_drain[NS], m_armed[NS], m_sum[NS], m_exp[NS];

   task automatic chk(input string tag, input int act, input int expv);
      n_tests++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic int m_pready();
      return (m_drain[m_pidx] == m_pph) ? 1 : 0;
   endfunction

   function automatic int m_cready();
      return (m_fill[m_cidx] != m_cph) ? 1 : 0;
   endfunction

   function automatic int pack(input int v[NS]);
      int r = 0;
      for (int s = 0; s < NS; s++) r |= (v[s] & 1) << s;
      return r;
   endfunction

   task automatic model_reset();
      m_pidx = 0; m_pph = 0; m_cidx = 0; m_cph = 0; m_err = 0; m_errst = 0;
      for (int s = 0; s < NS; s++) begin
         m_fill[s] = 0; m_drain[s] = 0; m_armed[s] = 0; m_sum[s] = 0; m_exp[s] = 0;
      end
   endtask

   task automatic check_all();
      chk("R3 prod_ready", int'(prod_ready), m_pready());
      chk("R2 prod_stage", int'(prod_stage), m_pidx);
      chk("R2 prod_lap", int'(prod_lap), m_pph);
      chk("R2 prod_slot_addr", int'(prod_slot_addr), m_pidx * SLOT);
      chk("R6 cons_ready", int'(cons_ready), m_cready());
      chk("R6 cons_stage", int'(cons_stage), m_cidx);
      chk("R6 cons_lap", int'(cons_lap), m_cph);
      chk("R6 cons_slot_addr", int'(cons_slot_addr), m_cidx * SLOT);
      chk("R4 fill_phase", int'(fill_phase), pack(m_fill));
      chk("R7 drain_phase", int'(drain_phase), pack(m_drain));
      chk("R4 armed", int'(armed), pack(m_armed));
      chk("R8 fill_err", int'(fill_err), m_err);
      if (m_err != 0) chk("R9 fill_err_stage", int'(fill_err_stage), m_errst);
   endtask

   // Check current outputs, drive one cycle of inputs, advance the model
   task automatic step(input bit acq, input int a, input int b, input bit av,
                       input int ast, input int ab, input bit rel);
      int pr, cr, tot;
      check_all();
      prod_acq = acq; bytes_a = BW'(a); bytes_b = BW'(b);
      arr_valid = av; arr_stage = IW'(ast); arr_bytes = CW'(ab);
      cons_release = rel;
      pr = m_pready(); cr = m_cready();
      m_err = 0;
      if (av) begin
         m_errst = ast;
         if (ast >= NS) m_err = 1;
         else if (m_armed[ast] == 0 || m_sum[ast] + ab > m_exp[ast]) m_err = 1;
         else if (m_sum[ast] + ab == m_exp[ast]) begin
            m_sum[ast] = 0; m_armed[ast] = 0; m_fill[ast] ^= 1;
         end else m_sum[ast] += ab;
      end
      if (acq && pr == 1) begin
         tot = a + b;
         m_sum[m_pidx] = 0;
         if (tot == 0) m_fill[m_pidx] ^= 1;
         else begin m_armed[m_pidx] = 1; m_exp[m_pidx] = tot; end
         if (m_pidx == NS - 1) begin m_pidx = 0; m_pph ^= 1; end else m_pidx++;
      end
      if (rel && cr == 1) begin
         m_drain[m_cidx] ^= 1;
         if (m_cidx == NS - 1) begin m_cidx = 0; m_cph ^= 1; end else m_cidx++;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int seed, tgt, rem, ab;
      seed = $urandom(32'd4711);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 prod_ready", int'(prod_ready), 1);
      chk("R1 cons_ready", int'(cons_ready), 0);
      chk("R1 phases", int'({fill_phase, drain_phase, armed}), 0);
      chk("R1 fill_err", int'(fill_err), 0);
      idle(1);

      // R3: three slots taken with no release, fourth refused
      step(1, 1, 3, 0, 0, 0, 0);
      step(1, 2, 2, 0, 0, 0, 0);
      step(1, 4, 4, 0, 0, 0, 0);
      chk("R3 ring full stalls", int'(prod_ready), 0);
      chk("R2 lap after wrap", int'(prod_lap), 1);
      step(1, 1, 1, 0, 0, 0, 0);
      chk("R3 refused acquire", int'(prod_stage), 0);

      // R6: release before fill is ignored
      step(0, 0, 0, 0, 0, 0, 1);
      chk("R6 early release ignored", int'(cons_stage), 0);

      // R4: partial then completing arrivals on slot 0 (total 4)
      step(0, 0, 0, 1, 0, 2, 0);
      chk("R4 partial not filled", int'(cons_ready), 0);
      step(0, 0, 0, 1, 0, 2, 0);
      chk("R4 exact sum fills", int'(cons_ready), 1);
      chk("R4 disarmed", int'(armed[0]), 0);

      // R8: overshoot on slot 1 (total 4, send 5)
      step(0, 0, 0, 1, 1, 5, 0);
      chk("R8 overshoot flagged", int'(fill_err), 1);
      chk("R8 overshoot stage", int'(fill_err_stage), 1);
      chk("R8 still armed", int'(armed[1]), 1);
      step(0, 0, 0, 1, 1, 4, 0);
      chk("R8 sum kept, exact fills", int'(fill_phase[1]), 1);

      // R9: out-of-range stage and unarmed slot
      step(0, 0, 0, 1, 3, 1, 0);
      chk("R9 range error", int'(fill_err), 1);
      chk("R9 range error stage", int'(fill_err_stage), 3);
      step(0, 0, 0, 1, 0, 1, 0);
      chk("R9 unarmed error", int'(fill_err), 1);

      // R7: release slot 0, producer may take it on lap 1
      step(0, 0, 0, 0, 0, 0, 1);
      chk("R7 drain phase flipped", int'(drain_phase[0]), 1);
      chk("R7 producer free again", int'(prod_ready), 1);

      // R5: zero-byte acquire completes at once
      step(1, 0, 0, 0, 0, 0, 0);
      chk("R5 zero total fills", int'(fill_phase[0]), 0);
      chk("R5 zero total not armed", int'(armed[0]), 0);
      idle(2);

      // Random traffic, mostly aimed at armed slots
      for (int i = 0; i < 4000; i++) begin
         bit acq, av, rel;
         int a, b;
         acq = ($urandom % 3) != 0;
         a = ($urandom % 8 == 0) ? 0 : $urandom % 16;
         b = $urandom % 16;
         rel = ($urandom % 3) != 0;
         av = ($urandom % 4) != 0;
         tgt = -1;
         for (int s = 0; s < NS; s++) if (m_armed[s] != 0 && tgt < 0) tgt = s;
         if (tgt < 0 || $urandom % 12 == 0) begin
            tgt = $urandom % 4;
            ab = 1 + $urandom % 8;
         end else begin
            rem = m_exp[tgt] - m_sum[tgt];
            ab = ($urandom % 10 == 0) ? rem + 1 : 1 + $urandom % rem;
         end
         step(acq, a, b, av, tgt, ab, rel);
      end
      check_all();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule